// File: doc/BRIEF.md
# 8-bit ALU with status flags

A purely combinational arithmetic and logic unit for a small 8-bit processor core. Each cycle it receives two operands, the current status byte and an operation code, and it returns a result byte together with the next status byte. The carry input for the carrying and rotating operations comes from the carry bit of the incoming status byte. There is no clock and no state inside the block.

Each operation writes its own fixed set of status flags and passes every other flag through unchanged. The enclosing core loads the returned status byte back into its status register. The caller picks the source of the second operand, either another register or a constant. The interrupt-enable and transfer bits always pass through untouched.

Top module: `alu8_core`

## Requirements
- R1: The status byte carries I, T, H, S, V, N, Z, C at bits 7 down to 0. No operation changes I (bit 7) or T (bit 6). With all inputs zero and code 0, the result is 0x00 and the status is 0x02.
- R2: ADD (code 0) and ADC (code 1, which adds status bit 0) return a+b(+C) mod 256. They write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N, Z and S.
- R3: SUB (code 2) and SBC (code 3, which also subtracts status bit 0) return a-b(-C) mod 256. They write C (borrow), H (borrow from bit 4), V, N and S. SUB sets Z when the result is zero. SBC keeps the old Z when the result is zero and clears Z otherwise.
- R4: AND (4), OR (5) and XOR (6) write Z, N and S, clear V, and keep C and H.
- R5: COM (7) returns 0xFF-a, sets C, clears V, writes Z, N and S, and keeps H.
- R6: NEG (8) returns 0x00-a and writes C (set when a is not zero), H, V (set only for a = 0x80), N, Z and S.
- R7: INC (9) and DEC (10) write only Z, N, V and S. V is set for INC of 0x7F and for DEC of 0x80, and C and H are kept.
- R8: LSL (11), LSR (12) and ASR (15) shift by one place. C receives the bit shifted out, ASR keeps bit 7, and H is kept.
- R9: ROL (13) shifts the old C into bit 0, and ROR (14) shifts it into bit 7. The bit shifted out becomes the new C.
- R10: After any shift or rotate, V equals N XOR the new C.
- R11: Whenever an operation writes N or V, S equals N XOR V.
- R12: SWAP (16) exchanges the two nibbles of a and leaves the status byte unchanged.
- R13: Codes 17 to 31 return a unchanged and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand, and the only operand of single-operand codes |
| opnd_b | input | 8 | Second operand (register or constant) |
| status_in | input | 8 | Current status byte; bit 0 is the carry input |
| result | output | 8 | Operation result |
| status_out | output | 8 | Next status byte |

## Verification
The hardest cases to reach from the ports are the flag pass-through cases, such as SBC preserving a set Z when the difference is zero, or INC keeping a set carry. A port-level bench only sees these when it offers a status byte whose untouched bits differ from what the operation would compute. The sweep therefore builds each incoming status byte from the operands, so both carry values and both old-Z values meet every operation. Directed cases then force the exact overflow edges 0x7F/0x80, a zero SBC difference with Z both set and clear, and rotates of a zero operand through a set carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;

  // status bit positions
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [OP_W-1:0] OP_ADD  = 5'd0;
  localparam logic [OP_W-1:0] OP_ADC  = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 5'd2;
  localparam logic [OP_W-1:0] OP_SBC  = 5'd3;
  localparam logic [OP_W-1:0] OP_AND  = 5'd4;
  localparam logic [OP_W-1:0] OP_OR   = 5'd5;
  localparam logic [OP_W-1:0] OP_XOR  = 5'd6;
  localparam logic [OP_W-1:0] OP_COM  = 5'd7;
  localparam logic [OP_W-1:0] OP_NEG  = 5'd8;
  localparam logic [OP_W-1:0] OP_INC  = 5'd9;
  localparam logic [OP_W-1:0] OP_DEC  = 5'd10;
  localparam logic [OP_W-1:0] OP_LSL  = 5'd11;
  localparam logic [OP_W-1:0] OP_LSR  = 5'd12;
  localparam logic [OP_W-1:0] OP_ROL  = 5'd13;
  localparam logic [OP_W-1:0] OP_ROR  = 5'd14;
  localparam logic [OP_W-1:0] OP_ASR  = 5'd15;
  localparam logic [OP_W-1:0] OP_SWAP = 5'd16;

  typedef enum logic [1:0] {CL_ARITH, CL_LOGIC, CL_SHIFT} op_class_e;

  function automatic op_class_e op_class(input logic [OP_W-1:0] op);
    if (op <= OP_SBC || (op >= OP_NEG && op <= OP_DEC)) return CL_ARITH;
    if (op >= OP_LSL && op <= OP_ASR) return CL_SHIFT;
    return CL_LOGIC;
  endfunction

  // flags each operation is allowed to write
  function automatic logic [7:0] flag_mask(input logic [OP_W-1:0] op);
    logic [7:0] m;
    m = '0;
    if (op <= OP_SBC || op == OP_NEG)
      m = 8'h3F;                                   // H S V N Z C
    else if ((op >= OP_AND && op <= OP_XOR) || op == OP_INC || op == OP_DEC)
      m = 8'h1E;                                   // S V N Z
    else if (op == OP_COM || (op >= OP_LSL && op <= OP_ASR))
      m = 8'h1F;                                   // S V N Z C
    return m;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            c_out,
  output logic            h_out,
  output logic            v_out
);
  localparam int HB = W / 2;

  logic [W-1:0] x, y, yy;
  logic         sub, ci, cc;
  logic [W:0]   full_sum;
  logic [HB:0]  half_sum;

  // one shared adder: operand steering per code
  always_comb begin
    x = a; y = b; sub = 1'b0; ci = 1'b0;
    case (op)
      OP_ADC: ci = cin;
      OP_SUB: sub = 1'b1;
      OP_SBC: begin sub = 1'b1; ci = cin; end
      OP_NEG: begin x = '0; y = a; sub = 1'b1; end
      OP_INC: y = W'(1);
      OP_DEC: begin y = W'(1); sub = 1'b1; end
      default: ;
    endcase
  end

  // subtraction as x + ~y + ~borrow_in
  assign yy = sub ? ~y : y;
  assign cc = sub ? ~ci : ci;

  assign full_sum = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, cc};
  assign half_sum = {1'b0, x[HB-1:0]} + {1'b0, yy[HB-1:0]} + {{HB{1'b0}}, cc};

  assign res   = full_sum[W-1:0];
  assign c_out = full_sum[W] ^ sub;
  assign h_out = half_sum[HB] ^ sub;
  assign v_out = (x[W-1] == yy[W-1]) && (full_sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res
);
  localparam int HB = W / 2;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            c_out
);
  logic fill_hi, fill_lo, left;

  always_comb begin
    left    = (op == OP_LSL) || (op == OP_ROL);
    fill_lo = (op == OP_ROL) ? cin : 1'b0;
    case (op)
      OP_ROR:  fill_hi = cin;
      OP_ASR:  fill_hi = a[W-1];
      default: fill_hi = 1'b0;
    endcase
    if (left) begin
      res   = {a[W-2:0], fill_lo};
      c_out = a[W-1];
    end else begin
      res   = {fill_hi, a[W-1:1]};
      c_out = a[0];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [7:0]      st_in,
  input  logic [W-1:0]    res,
  input  logic            ar_c,
  input  logic            ar_h,
  input  logic            ar_v,
  input  logic            sh_c,
  output logic [7:0]      wr_mask,
  output logic [7:0]      st_out
);
  op_class_e  cls;
  logic       n_bit, zero_res;
  logic [7:0] nf;

  assign cls      = op_class(op);
  assign n_bit    = res[W-1];
  assign zero_res = ~|res;
  assign wr_mask  = flag_mask(op);

  always_comb begin
    nf = st_in;
    case (cls)
      CL_ARITH: begin nf[FC] = ar_c; nf[FH] = ar_h; nf[FV] = ar_v; end
      CL_SHIFT: begin nf[FC] = sh_c; nf[FV] = n_bit ^ sh_c; end
      default:  begin nf[FC] = 1'b1; nf[FV] = 1'b0; end
    endcase
    nf[FN] = n_bit;
    nf[FZ] = (op == OP_SBC) ? (zero_res & st_in[FZ]) : zero_res;
    nf[FS] = n_bit ^ nf[FV];
  end

  assign st_out = (nf & wr_mask) | (st_in & ~wr_mask);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [7:0]   status_in,
  output logic [W-1:0] result,
  output logic [7:0]   status_out
);
  logic [W-1:0] arith_res, logic_res, shift_res;
  logic         arith_c, arith_h, arith_v, shift_c;
  logic [7:0]   wr_mask;
  op_class_e    cls;

  alu8_arith #(.W(W)) u_arith (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .cin(status_in[FC]),
    .res(arith_res), .c_out(arith_c), .h_out(arith_h), .v_out(arith_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .res(logic_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .op(op_sel), .a(opnd_a), .cin(status_in[FC]),
    .res(shift_res), .c_out(shift_c)
  );

  assign cls = op_class(op_sel);

  always_comb begin
    case (cls)
      CL_ARITH: result = arith_res;
      CL_SHIFT: result = shift_res;
      default:  result = logic_res;
    endcase
  end

  alu8_flags #(.W(W)) u_flags (
    .op(op_sel), .st_in(status_in), .res(result),
    .ar_c(arith_c), .ar_h(arith_h), .ar_v(arith_v), .sh_c(shift_c),
    .wr_mask(wr_mask), .st_out(status_out)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic [4:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [7:0]   status_in,
  input logic [W-1:0] result,
  input logic [7:0]   status_out,
  input logic [7:0]   wr_mask
);
  localparam int HB = W / 2;

  always_comb begin
    // R1
    it_keep_chk: assert (status_out[7:6] == status_in[7:6])
      else $error("I or T changed");
    // R13
    mask_keep_chk: assert ((status_out & ~wr_mask) == (status_in & ~wr_mask))
      else $error("flag outside write set changed");
    // R11
    if (wr_mask[4])
      s_rule_chk: assert (status_out[4] == (status_out[2] ^ status_out[3]))
        else $error("S is not N xor V");
    // R10
    if (op_sel >= 5'd11 && op_sel <= 5'd15)
      shift_v_chk: assert (status_out[3] == (status_out[2] ^ status_out[0]))
        else $error("shift V is not N xor C");
    // R5
    if (op_sel == 5'd7)
      com_cv_chk: assert (status_out[0] && !status_out[3])
        else $error("COM must set C and clear V");
    // R7
    if (op_sel == 5'd9 || op_sel == 5'd10)
      incdec_keep_chk: assert (status_out[0] == status_in[0] && status_out[5] == status_in[5])
        else $error("INC/DEC touched C or H");
    // R12
    if (op_sel == 5'd16)
      swap_chk: assert (result == {opnd_a[HB-1:0], opnd_a[W-1:HB]} && status_out == status_in)
        else $error("SWAP wrong");
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .op_sel(op_sel), .opnd_a(opnd_a), .status_in(status_in),
  .result(result), .status_out(status_out), .wr_mask(wr_mask)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, status_in = '0;
  logic [7:0] result, status_out;
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;   // 250 MHz

  alu8_core u_dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .status_in(status_in), .result(result), .status_out(status_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int sg(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // independent integer model: returns {result, status}
  function automatic logic [15:0] model(input int op, input int a, input int b, input logic [7:0] st);
    int c, r, x, y, sv;
    logic [7:0] f;
    f = st; c = st[0]; r = a;
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        r = a + b + c; f[0] = (r > 255);
        f[5] = ((a % 16) + (b % 16) + c) > 15;
        sv = sg(a) + sg(b) + c; f[3] = (sv > 127) || (sv < -128);
        r = r % 256;
      end
      2, 3, 8: begin
        if (op == 8) begin x = 0; y = a; end else begin x = a; y = b; end
        if (op != 3) c = 0;
        r = x - y - c; f[0] = (r < 0);
        f[5] = ((x % 16) - (y % 16) - c) < 0;
        sv = sg(x) - sg(y) - c; f[3] = (sv > 127) || (sv < -128);
        r = (r + 512) % 256;
      end
      4: begin r = a & b; f[3] = 1'b0; end
      5: begin r = a | b; f[3] = 1'b0; end
      6: begin r = a ^ b; f[3] = 1'b0; end
      7: begin r = 255 - a; f[0] = 1'b1; f[3] = 1'b0; end
      9: begin r = (a + 1) % 256; f[3] = (a == 127); end
      10: begin r = (a + 255) % 256; f[3] = (a == 128); end
      11: begin r = (a * 2) % 256; f[0] = (a >= 128); end
      12: begin r = a / 2; f[0] = a % 2; end
      13: begin r = (a * 2) % 256 + c; f[0] = (a >= 128); end
      14: begin r = a / 2 + 128 * c; f[0] = a % 2; end
      15: begin r = a / 2 + ((a >= 128) ? 128 : 0); f[0] = a % 2; end
      16: r = (a % 16) * 16 + a / 16;
      default: r = a;
    endcase
    if (op <= 15) begin
      f[2] = (r >= 128);
      if (op >= 11) f[3] = f[2] ^ f[0];
      f[1] = (r == 0) && (op != 3 || st[1]);
      f[4] = f[2] ^ f[3];
    end
    return {r[7:0], f};
  endfunction

  task automatic drive(input int op, input int a, input int b, input logic [7:0] st);
    @(negedge clk);
    op_sel = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; status_in = st;
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] er, input logic [7:0] es);
    n_tests++;
    if (result !== er || status_out !== es) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h st=%h: got r=%h s=%h, expected r=%h s=%h",
               tag, op_sel, opnd_a, opnd_b, status_in, result, status_out, er, es);
    end
  endtask

  task automatic t_sweep(input int op, input string tag);
    logic [15:0] e;
    for (int a = 0; a < 256; a++) begin
      for (int ci = 0; ci < 2; ci++) begin
        int b;
        logic [7:0] st;
        b  = (a * 53 + 7 + ci * 101) % 256;
        st = 8'((a * 29 + b) % 256);
        st[0] = ci[0];
        drive(op, a, b, st);
        e = model(op, a, b, st);
        check(tag, e[15:8], e[7:0]);
      end
    end
  endtask

  task automatic t_reset;
    drive(0, 0, 0, 8'h00);
    check("R1 reset", 8'h00, 8'h02);
  endtask

  task automatic t_corners;
    drive(0, 8'h7F, 8'h01, 8'h00);   check("R2 0x7F+1", 8'h80, 8'h2C);
    drive(3, 5, 5, 8'h00);           check("R3 SBC zero Z clear", 8'h00, 8'h00);
    drive(3, 5, 5, 8'h02);           check("R3 SBC zero Z set", 8'h00, 8'h02);
    drive(3, 5, 5, 8'hC2);           check("R1 I/T kept", 8'h00, 8'hC2);
    drive(8, 8'h80, 0, 8'h00);       check("R6 NEG 0x80", 8'h80, 8'h0D);
    drive(15, 8'h81, 0, 8'h00);      check("R10 R11 ASR", 8'hC0, 8'h15);
    drive(14, 8'h00, 0, 8'h01);      check("R9 ROR carry in", 8'h80, 8'h0C);
    drive(9, 8'h7F, 0, 8'h21);       check("R7 INC 0x7F", 8'h80, 8'h2D);
    drive(7, 8'h00, 0, 8'h20);       check("R5 COM 0", 8'hFF, 8'h35);
    drive(16, 8'hA5, 0, 8'h5A);      check("R12 SWAP", 8'h5A, 8'h5A);
    drive(25, 8'h3C, 8'hFF, 8'h99);  check("R13 unused code", 8'h3C, 8'h99);
  endtask

  task automatic t_unused;
    for (int op = 17; op < 32; op++) begin
      drive(op, op * 7, 8'h11, 8'hA6);
      check("R13", 8'(op * 7), 8'hA6);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_corners();
    t_sweep(0, "R2 ADD");  t_sweep(1, "R2 ADC");
    t_sweep(2, "R3 SUB");  t_sweep(3, "R3 SBC");
    t_sweep(4, "R4 AND");  t_sweep(5, "R4 OR");  t_sweep(6, "R4 XOR");
    t_sweep(7, "R5 COM");  t_sweep(8, "R6 NEG");
    t_sweep(9, "R7 INC");  t_sweep(10, "R7 DEC");
    t_sweep(11, "R8 LSL"); t_sweep(12, "R8 LSR"); t_sweep(15, "R8 ASR");
    t_sweep(13, "R9 ROL"); t_sweep(14, "R9 ROR");
    t_sweep(16, "R12 SWAP");
    t_unused();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule